// File: doc/BRIEF.md
# Gated Pixel Address Scanner

This block generates the address-switch enables for a linear photodiode array. A start pulse loads a single token into a chain of falling-edge flip-flops, one per pixel channel. The token moves one channel further on every falling clock edge. Each channel's enable is the NOR of its active-low stage output and a shared inhibit line. A pixel switch therefore turns on only while the token sits on that channel and inhibit is low.

A controller uses inhibit in two ways. It holds inhibit high around each falling clock edge so that two neighbouring switches never overlap during the handover. It also keeps inhibit high for a whole slot to skip a pixel, and that pixel then goes on integrating until a later scan. One extra stage after the last channel gives an end-of-scan pulse. Inhibit does not gate this pulse.

Top module: `pixel_scan_chain`

## Requirements
- R1: A falling clock edge with `rst_i` high clears every stage, so that `pix_en_o` is all zero and `scan_end_o` is low afterwards.
- R2: If `start_i` is high at a falling edge, channel 0 holds the token after that edge and `pix_en_o[0]` is 1 while `inhibit_i` is low.
- R3: On each following falling edge the token moves from channel k to channel k+1. Bit k of `pix_en_o` belongs to channel k, and channel 0 is scanned first.
- R4: `pix_en_o[k]` is 1 exactly when channel k holds the token and `inhibit_i` is 0. It follows `inhibit_i` with no clock delay.
- R5: While `inhibit_i` is 1, every bit of `pix_en_o` is 0. The token still advances, so that slot's pixel is skipped.
- R6: `scan_end_o` is 1 for exactly one clock period, in the slot right after the token leaves the last channel, whatever the level of `inhibit_i`.
- R7: When `start_i` is high at only one falling edge per scan, at most one bit of `pix_en_o` is 1 at any time.
- R8: A reset during a scan removes the token: no enable and no end-of-scan appear afterwards until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock; all stages update on its falling edge |
| rst_i | input | 1 | Synchronous reset, active high, sampled on the falling edge |
| start_i | input | 1 | Start pulse that loads the token into channel 0 |
| inhibit_i | input | 1 | Shared inhibit; high forces every enable low |
| pix_en_o | output | CHANNELS | One address-switch enable per channel, active high |
| scan_end_o | output | 1 | End-of-scan pulse from the extra stage, active high |

## Verification
Each stage is a single register on the falling edge. A start or advance is therefore visible on the outputs right after the falling edge where it was sampled. End-of-scan appears one edge after the token was in the last channel, which is CHANNELS+1 edges after start. Inhibit acts on the enables in the same cycle, with no edge in between.

The bench changes its inputs just after a sample point, so they are stable before the next falling edge. It samples two time units after each falling edge, which places every check in the slot where the result is due.

// File: rtl/pixel_scan_pkg.sv
package pixel_scan_pkg;
   // Level of an idle stage: the token is carried as a low level
   localparam logic STAGE_IDLE = 1'b1;
   // Smallest chain that still has a first and a last channel
   localparam int unsigned MIN_CHANNELS = 2;
endpackage

// File: rtl/scan_stage.sv
module scan_stage
   import pixel_scan_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic tok_n_i,
   output logic tok_n_o
);
   always_ff @(negedge clk_i) begin
      if (rst_i) tok_n_o <= STAGE_IDLE;
      else       tok_n_o <= tok_n_i;
   end
endmodule

// File: rtl/enable_nor_bank.sv
module enable_nor_bank #(
   parameter int unsigned WIDTH = 128
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] tok_n_i,
   input  logic             inhibit_i,
   output logic [WIDTH-1:0] en_o
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_nor
      assign en_o[g] = ~(tok_n_i[g] | inhibit_i);
   end

   // R5: inhibit overrides every enable
   a_r5_inhibit_blocks: assert property (@(negedge clk_i) disable iff (rst_i)
      inhibit_i |-> (en_o == '0));
endmodule

// File: rtl/pixel_scan_chain.sv
module pixel_scan_chain
   import pixel_scan_pkg::*;
#(
   parameter int unsigned CHANNELS = 128
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                start_i,
   input  logic                inhibit_i,
   output logic [CHANNELS-1:0] pix_en_o,
   output logic                scan_end_o
);
   localparam int unsigned STAGES = CHANNELS + 1;

   if (CHANNELS < MIN_CHANNELS) begin : g_bad_size
      $error("pixel_scan_chain: CHANNELS below minimum");
   end

   logic [STAGES-1:0] stage_d_n;
   logic [STAGES-1:0] stage_q_n;

   assign stage_d_n[0] = ~start_i;
   for (genvar g = 1; g < STAGES; g++) begin : g_link
      assign stage_d_n[g] = stage_q_n[g-1];
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      scan_stage u_stage (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .tok_n_i (stage_d_n[g]),
         .tok_n_o (stage_q_n[g])
      );
   end

   enable_nor_bank #(.WIDTH(CHANNELS)) u_nor (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tok_n_i   (stage_q_n[CHANNELS-1:0]),
      .inhibit_i (inhibit_i),
      .en_o      (pix_en_o)
   );

   assign scan_end_o = ~stage_q_n[CHANNELS];

   // R7: never two switches on together
   a_r7_single_enable: assert property (@(negedge clk_i) disable iff (rst_i)
      $onehot0(pix_en_o));
   // R2: a sampled start shows up on channel 0 unless inhibited
   a_r2_start_loads: assert property (@(negedge clk_i) disable iff (rst_i)
      start_i |=> (inhibit_i || pix_en_o[0]));
   // R6: end-of-scan follows the last channel
   a_r6_end_follows_last: assert property (@(negedge clk_i) disable iff (rst_i)
      (!stage_q_n[CHANNELS-1]) |=> scan_end_o);
   // R6: end-of-scan lasts a single slot
   a_r6_end_one_slot: assert property (@(negedge clk_i) disable iff (rst_i)
      scan_end_o |=> !scan_end_o);
endmodule

// File: tb/tb_pixel_scan_chain.sv
module tb_pixel_scan_chain;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int NVEC = 12;
   // {start, inhibit, expected enables[7:0], expected end-of-scan}
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 8'h00, 1'b0},
      {1'b0, 1'b0, 8'h02, 1'b0},
      {1'b0, 1'b0, 8'h04, 1'b0},
      {1'b0, 1'b1, 8'h00, 1'b0},
      {1'b0, 1'b0, 8'h10, 1'b0},
      {1'b0, 1'b0, 8'h20, 1'b0},
      {1'b0, 1'b1, 8'h00, 1'b0},
      {1'b0, 1'b0, 8'h80, 1'b0},
      {1'b0, 1'b1, 8'h00, 1'b1},
      {1'b0, 1'b0, 8'h00, 1'b0},
      {1'b1, 1'b0, 8'h01, 1'b0},
      {1'b0, 1'b0, 8'h02, 1'b0}
   };

   logic clk = 1'b1;
   logic rst, start, inhibit;
   logic [N-1:0] pix_en;
   logic scan_end;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pixel_scan_chain #(.CHANNELS(N)) dut (
      .clk_i(clk), .rst_i(rst), .start_i(start), .inhibit_i(inhibit),
      .pix_en_o(pix_en), .scan_end_o(scan_end)
   );

   task automatic check(string req, logic [N-1:0] exp_en, logic exp_end);
      checks++;
      if (pix_en !== exp_en || scan_end !== exp_end) begin
         fails++;
         $display("FAIL %s: en=%h end=%b expected en=%h end=%b",
                  req, pix_en, scan_end, exp_en, exp_end);
      end
   endtask

   task automatic step(logic s, logic h);
      start = s;
      inhibit = h;
      @(negedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      rst = 1; start = 0; inhibit = 0;
      @(negedge clk); @(negedge clk); #2;
      // R1: reset state
      check("R1", '0, 1'b0);
      rst = 0;
      // Table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][10], VEC[i][9]);
         check($sformatf("R3/R5/R6 vec%0d", i), VEC[i][8:1], VEC[i][0]);
      end
      // R4: inhibit acts without a clock edge (token in channel 1 now)
      inhibit = 1; #1;
      check("R4 inhibit rise", '0, 1'b0);
      inhibit = 0; #1;
      check("R4 inhibit fall", 8'h02, 1'b0);
      // R8: reset mid-scan drops the token
      rst = 1;
      step(0, 0);
      rst = 0;
      check("R8 reset", '0, 1'b0);
      for (int i = 0; i < N + 2; i++) begin
         step(0, 0);
         check("R8 no token", '0, 1'b0);
      end
      // R2 R7: full scan with inhibit low, one channel at a time
      step(1, 0);
      check("R2 load", 8'h01, 1'b0);
      for (int i = 1; i < N; i++) begin
         step(0, 0);
         check("R7 scan", 8'h01 << i, 1'b0);
      end
      step(0, 0);
      check("R6 end", '0, 1'b1);
      step(0, 0);
      check("R6 single", '0, 1'b0);
      finish_run();
   end
endmodule